// File: doc/BRIEF.md
# Shared Sequential Multiply/Divide Unit

This block is an iterative integer arithmetic unit for a narrow single-issue pipeline. It computes either the full double-width unsigned product of two operands or the unsigned quotient and remainder of one operand divided by the other. Both operations run on the same hardware. There are two working registers, `hi` and `lo`, and one adder/subtractor of width W+1. For a product the register pair shifts toward the least significant end. For a division it shifts toward the most significant end.

The unit takes exactly two source operands, so it fits a register file with two read ports. A pulse on `start` while the unit is not busy loads the operands and the operation select. The unit then handles one operand bit per clock. After W iterations it raises `done` for one cycle. The result stays on `result` until the next start is accepted.

The controller has three states. IDLE is the state after reset. IDLE goes to RUN on an accepted start. RUN stays in RUN while iterations remain and goes to FINISH on the last iteration. FINISH presents `done`. From FINISH the controller goes to RUN if a new start arrives, and to IDLE otherwise.

Top module: `muldiv_seq`

## Requirements
- R1: With `op_div` = 0, `result` equals the unsigned product `opnd_a * opnd_b` over all 2W bits.
- R2: With `op_div` = 1 and a nonzero `opnd_b`, `result[W-1:0]` holds the quotient `opnd_a / opnd_b` and `result[2W-1:W]` holds the remainder `opnd_a % opnd_b`.
- R3: `done` is first high in the cycle after the W-th rising edge that follows the edge on which start was accepted.
- R4: With `op_div` = 1 and `opnd_b` = 0, the operation completes with the normal latency. The quotient half is all ones and the remainder half equals `opnd_a`.
- R5: `busy` is high for exactly the W cycles between acceptance and `done`. `busy` and `done` are never high in the same cycle.
- R6: `done` lasts one cycle. After it, `result` holds its value until the next accepted start.
- R7: A `start` raised while `busy` is high is ignored. The running operation finishes with its original operands and operation, and no extra `done` follows.
- R8: After reset `busy` = 0, `done` = 0 and `result` = 0.
- R9: During a division the partial remainder held in `hi` stays below the nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin; accepted only while not busy |
| op_div | input | 1 | 0 selects multiply, 1 selects divide |
| opnd_a | input | W | Multiplicand or dividend |
| opnd_b | input | W | Multiplier or divisor |
| result | output | 2W | Product, or {remainder, quotient} |
| busy | output | 1 | Iterations are in progress |
| done | output | 1 | One-cycle pulse: result is valid |

## Verification
A fault in the shift direction or in the carry used as the quotient bit damages every affected operation. It shows at the ports in the very next `done`, as a wrong product, a wrong quotient or a wrong remainder. An iteration counter that is off by one moves `done` by one cycle, so the next accepted operation has the wrong latency. A start that is wrongly accepted while busy either corrupts the result or produces an extra `done` within W cycles. The bench uses W = 5 and sweeps every operand pair for both operations, including divisor zero. It also applies directed corner vectors to a W = 32 copy.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } md_state_t;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_t;

endpackage

// File: rtl/muldiv_addsub.sv
module muldiv_addsub #(
    parameter int W = 32
) (
    input  logic [W:0] lhs,
    input  logic [W:0] rhs,
    input  logic       subtract,
    output logic [W:0] sum,
    output logic       carry
);
    localparam int AW = W + 2;

    logic [AW-1:0] full;
    logic [W:0]    rhs_eff;

    always_comb begin
        rhs_eff = subtract ? ~rhs : rhs;
        full    = {1'b0, lhs} + {1'b0, rhs_eff} + AW'(subtract);
        sum     = full[W:0];
        carry   = full[W+1];
    end
endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    md_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and iteration count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            end
            ST_RUN: begin
                if (cnt_q == LAST) begin
                    state_d = ST_FINISH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_FINISH: begin
                cnt_d   = '0;
                state_d = start ? ST_RUN : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_FINISH: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q <= LAST)); // R3

    AST_FINISH_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> (state_q != ST_FINISH)); // R6
endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic           busy,
    input  logic           start,
    input  logic           op_div,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    output logic [2*W-1:0] result
);
    logic [W-1:0] hi_q, lo_q, b_q;
    md_op_t       op_q;

    logic [W:0]   add_l, add_r, add_s;
    logic         add_c, add_sub;
    logic [W-1:0] hi_d, lo_d;

    // Operand routing into the shared adder
    always_comb begin
        if (op_q == OP_DIV) begin
            add_l   = {hi_q, lo_q[W-1]};
            add_r   = {1'b0, b_q};
            add_sub = 1'b1;
        end else begin
            add_l   = {1'b0, hi_q};
            add_r   = lo_q[0] ? {1'b0, b_q} : '0;
            add_sub = 1'b0;
        end
    end

    muldiv_addsub #(.W(W)) u_addsub (
        .lhs      (add_l),
        .rhs      (add_r),
        .subtract (add_sub),
        .sum      (add_s),
        .carry    (add_c)
    );

    // One iteration: right shift for multiply, left shift for divide
    always_comb begin
        if (op_q == OP_DIV) begin
            hi_d = add_c ? add_s[W-1:0] : add_l[W-1:0];
            lo_d = {lo_q[W-2:0], add_c};
        end else begin
            hi_d = add_s[W:1];
            lo_d = {add_s[0], lo_q[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
            b_q  <= '0;
            op_q <= OP_MUL;
        end else if (load) begin
            hi_q <= '0;
            lo_q <= opnd_a;
            b_q  <= opnd_b;
            op_q <= md_op_t'(op_div);
        end else if (step) begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    assign result = {hi_q, lo_q};

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_DIV && b_q != '0) |-> (hi_q < b_q)); // R9

    AST_BUSY_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(b_q) && $stable(op_q))); // R7
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           op_div,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    output logic [2*W-1:0] result,
    output logic           busy,
    output logic           done
);
    localparam int CW = $clog2(W + 2);

    logic load, step;

    muldiv_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    muldiv_datapath #(.W(W)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .busy   (busy),
        .start  (start),
        .op_div (op_div),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .result (result)
    );

    // Cycles since acceptance, kept for the latency check
    logic [CW-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lat_q <= '0;
        else if (load)     lat_q <= '0;
        else if (busy)     lat_q <= lat_q + 1'b1;
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == CW'(W))); // R3

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> $stable(result)); // R6
endmodule

// File: tb/muldiv_seq_test.sv
module muldiv_seq_test;
    localparam int TW = 5;
    localparam int WW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              s_start = 0, s_op = 0;
    logic [TW-1:0]     s_a = 0, s_b = 0;
    logic [2*TW-1:0]   s_res;
    logic              s_busy, s_done;

    logic              w_start = 0, w_op = 0;
    logic [WW-1:0]     w_a = 0, w_b = 0;
    logic [2*WW-1:0]   w_res;
    logic              w_busy, w_done;

    muldiv_seq #(.W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .start(s_start), .op_div(s_op),
        .opnd_a(s_a), .opnd_b(s_b), .result(s_res), .busy(s_busy), .done(s_done));

    muldiv_seq #(.W(WW)) uut_wide (
        .clk(clk), .rst_n(rst_n), .start(w_start), .op_div(w_op),
        .opnd_a(w_a), .opnd_b(w_b), .result(w_res), .busy(w_busy), .done(w_done));

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 0;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2*TW-1:0] ref_s(input logic op, input logic [TW-1:0] a, input logic [TW-1:0] b);
        if (!op)      return (2*TW)'(a) * (2*TW)'(b);
        if (b == 0)   return {a, {TW{1'b1}}};
        return {a % b, a / b};
    endfunction

    function automatic logic [2*WW-1:0] ref_w(input logic op, input logic [WW-1:0] a, input logic [WW-1:0] b);
        if (!op)      return (2*WW)'(a) * (2*WW)'(b);
        if (b == 0)   return {a, {WW{1'b1}}};
        return {a % b, a / b};
    endfunction

    // One operation on the small unit; optional stray start while busy
    task automatic run_s(input logic op, input logic [TW-1:0] a, input logic [TW-1:0] b,
                         input bit stray, input bit full);
        int n;
        int busy_cnt;
        logic [2*TW-1:0] exp;
        exp = ref_s(op, a, b);
        @(negedge clk);
        s_start = 1; s_op = op; s_a = a; s_b = b;
        @(negedge clk);
        s_start = 0;
        n = 0; busy_cnt = 0;
        while (!s_done && n < 4*TW) begin
            if (s_busy) busy_cnt++;
            if (stray && n == 2) begin
                s_start = 1; s_op = ~op; s_a = ~a; s_b = ~b;
            end else begin
                s_start = 0;
            end
            @(negedge clk);
            n++;
        end
        s_start = 0;
        if (s_done && s_busy) chk("R5 busy with done", 1, 0);
        chk(op ? (b == 0 ? "R4 div by zero" : "R2 divide") : "R1 multiply", s_res, exp);
        if (full) begin
            chk("R3 latency", n, TW);
            chk("R5 busy cycles", busy_cnt, TW);
            @(negedge clk);
            chk("R6 done width", s_done, 0);
            chk("R6 result held", s_res, exp);
            if (stray) begin
                repeat (TW + 2) begin
                    @(negedge clk);
                    if (s_done || s_busy) chk("R7 extra run", 1, 0);
                end
                chk("R7 stray start ignored", s_res, exp);
            end
        end
    endtask

    task automatic run_w(input logic op, input logic [WW-1:0] a, input logic [WW-1:0] b);
        int n;
        logic [2*WW-1:0] exp;
        exp = ref_w(op, a, b);
        @(negedge clk);
        w_start = 1; w_op = op; w_a = a; w_b = b;
        @(negedge clk);
        w_start = 0;
        n = 0;
        while (!w_done && n < 4*WW) begin
            @(negedge clk);
            n++;
        end
        chk(op ? (b == 0 ? "R4 wide div by zero" : "R2 wide divide") : "R1 wide multiply", w_res, exp);
        chk("R3 wide latency", n, WW);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [WW-1:0] lf;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 busy at reset", s_busy, 0);
        chk("R8 done at reset", s_done, 0);
        chk("R8 result at reset", s_res, 0);
        chk("R8 wide result at reset", w_res, 0);
        rst_n = 1;
        @(negedge clk);

        // Exhaustive small sweep, both operations (R1, R2, R4)
        for (int op = 0; op < 2; op++)
            for (int a = 0; a < (1 << TW); a++)
                for (int b = 0; b < (1 << TW); b++)
                    run_s(op[0], TW'(a), TW'(b), 0, (a % 7 == 0));

        // R7 stray start during both operations, including divide by zero
        run_s(0, 5'd31, 5'd31, 1, 1);
        run_s(1, 5'd29, 5'd3, 1, 1);
        run_s(1, 5'd17, 5'd0, 1, 1);

        // Wide corners
        run_w(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_w(0, 32'h8000_0000, 32'h0000_0002);
        run_w(1, 32'hFFFF_FFFF, 32'h0000_0001);
        run_w(1, 32'hFFFF_FFFF, 32'h0000_0000);
        run_w(1, 32'h0000_0007, 32'hFFFF_FFFF);
        run_w(1, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
        run_w(1, 32'h8000_0000, 32'h8000_0000);
        lf = 32'h1234_5679;
        for (int i = 0; i < 40; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            run_w(i[0], lf, (i % 5 == 0) ? {16'h0, lf[31:16]} : ~lf);
        end
        finish_run();
    end
endmodule